// File: doc/BRIEF.md
# Handshaked Two-Line Message Transmitter

This block sends one 9-bit message across a two-wire link with open-drain lines. One line is the Attention line and the other is the Data line. Each line has a pull-up, and the block only ever pulls a line low. The message is a kind flag followed by a data byte. A flag of 1 marks an instruction and a flag of 0 marks plain data. A one-cycle start strobe loads the flag and the byte from the parallel inputs. The block then works through the bits and reports the result with a done pulse or a timeout pulse.

No free-running clock crosses the link, and the receiver may answer slowly. For each bit the transmitter:
- places the bit on Data;
- pulses Attention low, then releases it and samples it;
- repeats the pulse until it finds that the receiver is holding Attention low;
- answers by flipping the level it drives on Data;
- waits for the receiver to let Attention go, then frees Data.

Both line inputs are resynchronised through two flops before any decision uses them. A bound watchdog limits every wait on the far side, so a shorted or silent line cannot lock the block. The settle time, the Attention pulse length and the watchdog limit are parameters counted in clock cycles. The settle time must be at least 3 cycles, so that the synchroniser delay fits inside it.

Top module: `hs_link_tx`

## Requirements
- R1: While reset is held and right after it, att_pull_o, dat_pull_o, busy_o, done_o and timeout_o are all 0.
- R2: The kind flag is sent first, then the data byte from bit 7 down to bit 0. A bit value of 1 leaves Data released (high) and a 0 pulls Data low. The level is valid whenever Attention first goes low for that bit.
- R3: Before each bit, the block waits until resynchronised Attention reads high, and then until resynchronised Data reads high. It pulls neither line while it waits.
- R4: The Data level of a bit stays unchanged for at least SETTLE_CYC cycles before Attention is pulled low.
- R5: The block pulls Attention low for HOLD_CYC cycles and then releases it for SETTLE_CYC cycles before sampling it. If the line reads high, the pulse repeats.
- R6: When the sample finds Attention held low, the block inverts its Data drive while keeping Attention released. Data changes only while the block is not pulling Attention, except on a timeout.
- R7: Once resynchronised Attention reads high again after the acknowledge, the block releases Data and moves to the next bit. After the last bit, both lines are left released.
- R8: After the ninth bit, done_o pulses for exactly one cycle, and busy_o is low in that same cycle.
- R9: If the block spends TIMEOUT_CYC cycles in one waiting phase without progress, it does the following in the same cycle: releases both lines, pulses timeout_o for one cycle, drops busy_o and gives no done pulse. The waiting phases are line-idle wait, polling and acknowledge wait.
- R10: A start strobe while busy_o is high is ignored. The message in flight is sent unchanged, and no second message follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle strobe that loads flag_i and data_i when idle |
| flag_i | input | 1 | Kind flag: 1 instruction, 0 data |
| data_i | input | DATA_W | Data byte |
| att_line_i | input | 1 | Level read back from the Attention line |
| dat_line_i | input | 1 | Level read back from the Data line |
| att_pull_o | output | 1 | 1 pulls the Attention line low |
| dat_pull_o | output | 1 | 1 pulls the Data line low |
| busy_o | output | 1 | High while a message is in progress |
| done_o | output | 1 | One-cycle pulse when a message completes |
| timeout_o | output | 1 | One-cycle pulse when a wait is abandoned |

## Verification
The assertions assume that the line inputs are the wired-AND of this block's own pulls and the far side's pulls. They also assume that the receiver drives only Attention and only in answer to a low Attention level, so Data moves only under this block's control. The bench meets these assumptions with a negedge receiver model that computes both line levels from the pull enables. The stuck-line and held-Data cases are produced only through extra pull-down terms on the same lines. All stimulus changes one time unit after a rising edge. Parameters stay at their defaults, with a settle time of 4, which is above the synchroniser depth.

// File: rtl/hs_tx_pkg.sv
package hs_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_ATT,
    ST_WAIT_DAT,
    ST_SETUP,
    ST_PULL,
    ST_RELAX,
    ST_ACK
  } tx_state_e;

  // Groups of states sharing one watchdog window
  typedef enum logic [1:0] {
    GRP_NONE,
    GRP_LINES,
    GRP_POLL,
    GRP_ACK
  } wait_grp_e;

  function automatic wait_grp_e grp_of(input tx_state_e s);
    wait_grp_e g;
    case (s)
      ST_WAIT_ATT, ST_WAIT_DAT, ST_SETUP: g = GRP_LINES;
      ST_PULL, ST_RELAX:                  g = GRP_POLL;
      ST_ACK:                             g = GRP_ACK;
      default:                            g = GRP_NONE;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/hs_tx_sync.sv
module hs_tx_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;

    // Idle level of a pulled-up line is high
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q <= '1;
      end else begin
        pipe_q <= {pipe_q[STAGES-2:0], d_i[g]};
      end
    end

    assign q_o[g] = pipe_q[STAGES-1];
  end

endmodule

// File: rtl/hs_tx_delay.sv
module hs_tx_delay #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  input  logic         en_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = value_i;
    end else if (en_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/hs_tx_shift.sv
module hs_tx_shift #(
  parameter int BITS = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [BITS-1:0] msg_i,
  input  logic            adv_i,
  output logic            bit_o,
  output logic            last_o
);

  localparam int IW = $clog2(BITS);
  localparam logic [IW-1:0] LAST_IDX = IW'(BITS - 1);

  logic [BITS-1:0] msg_q, msg_d;
  logic [IW-1:0]   idx_q, idx_d;

  always_comb begin
    msg_d = msg_q;
    idx_d = idx_q;
    if (load_i) begin
      msg_d = msg_i;
      idx_d = '0;
    end else if (adv_i) begin
      msg_d = {msg_q[BITS-2:0], 1'b0};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_q <= '0;
      idx_q <= '0;
    end else begin
      msg_q <= msg_d;
      idx_q <= idx_d;
    end
  end

  assign bit_o  = msg_q[BITS-1];
  assign last_o = (idx_q == LAST_IDX);

endmodule

// File: rtl/hs_link_tx.sv
module hs_link_tx
  import hs_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SETTLE_CYC  = 4,
  parameter int HOLD_CYC    = 6,
  parameter int TIMEOUT_CYC = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              flag_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              att_line_i,
  input  logic              dat_line_i,
  output logic              att_pull_o,
  output logic              dat_pull_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);

  localparam int MSG_BITS = DATA_W + 1;
  localparam int DLY_MAX  = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
  localparam int DLY_W    = $clog2(DLY_MAX + 1);
  localparam int WD_W     = $clog2(TIMEOUT_CYC + 1);
  localparam logic [DLY_W-1:0] SETTLE_LD = DLY_W'(SETTLE_CYC - 1);
  localparam logic [DLY_W-1:0] HOLD_LD   = DLY_W'(HOLD_CYC - 1);
  localparam logic [WD_W-1:0]  WD_LD     = WD_W'(TIMEOUT_CYC - 1);

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n = rst_pipe_q[1];

  // Line resynchronisation
  logic att_s, dat_s;

  hs_tx_sync #(
    .LINES  (2),
    .STAGES (2)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    ({att_line_i, dat_line_i}),
    .q_o    ({att_s, dat_s})
  );

  // Control signals
  tx_state_e        state_q, state_d;
  logic             dly_load, dly_zero;
  logic [DLY_W-1:0] dly_val;
  logic             wd_load, wd_en, wd_zero, wd_expired;
  logic             load_msg, adv_bit, tx_bit, last_bit;
  logic             att_pull_d, dat_pull_d, done_d, timeout_d;

  hs_tx_delay #(
    .W (DLY_W)
  ) u_phase_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .load_i  (dly_load),
    .value_i (dly_val),
    .en_i    (1'b1),
    .zero_o  (dly_zero)
  );

  hs_tx_delay #(
    .W (WD_W)
  ) u_watchdog (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .load_i  (wd_load),
    .value_i (WD_LD),
    .en_i    (wd_en),
    .zero_o  (wd_zero)
  );

  hs_tx_shift #(
    .BITS (MSG_BITS)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .load_i (load_msg),
    .msg_i  ({flag_i, data_i}),
    .adv_i  (adv_bit),
    .bit_o  (tx_bit),
    .last_o (last_bit)
  );

  assign wd_en      = (grp_of(state_q) != GRP_NONE);
  assign wd_expired = wd_en && wd_zero;

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    dly_load  = 1'b0;
    dly_val   = SETTLE_LD;
    load_msg  = 1'b0;
    adv_bit   = 1'b0;
    done_d    = 1'b0;
    timeout_d = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_msg = 1'b1;
          state_d  = ST_WAIT_ATT;
        end
      end
      ST_WAIT_ATT: begin
        if (att_s) begin
          state_d = ST_WAIT_DAT;
        end
      end
      ST_WAIT_DAT: begin
        if (dat_s) begin
          state_d  = ST_SETUP;
          dly_load = 1'b1;
          dly_val  = SETTLE_LD;
        end
      end
      ST_SETUP: begin
        if (dly_zero) begin
          state_d  = ST_PULL;
          dly_load = 1'b1;
          dly_val  = HOLD_LD;
        end
      end
      ST_PULL: begin
        if (dly_zero) begin
          state_d  = ST_RELAX;
          dly_load = 1'b1;
          dly_val  = SETTLE_LD;
        end
      end
      ST_RELAX: begin
        if (dly_zero) begin
          if (!att_s) begin
            state_d = ST_ACK;
          end else begin
            state_d  = ST_PULL;
            dly_load = 1'b1;
            dly_val  = HOLD_LD;
          end
        end
      end
      ST_ACK: begin
        if (att_s) begin
          adv_bit = 1'b1;
          if (last_bit) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_WAIT_ATT;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (wd_expired) begin
      state_d   = ST_IDLE;
      dly_load  = 1'b0;
      adv_bit   = 1'b0;
      done_d    = 1'b0;
      timeout_d = 1'b1;
    end
  end

  assign wd_load = (grp_of(state_d) != grp_of(state_q));

  // Line drive for the state being entered
  always_comb begin
    att_pull_d = (state_d == ST_PULL);
    case (state_d)
      ST_SETUP, ST_PULL, ST_RELAX: dat_pull_d = ~tx_bit;
      ST_ACK:                      dat_pull_d = tx_bit;
      default:                     dat_pull_d = 1'b0;
    endcase
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      att_pull_o <= 1'b0;
      dat_pull_o <= 1'b0;
      done_o     <= 1'b0;
      timeout_o  <= 1'b0;
    end else begin
      state_q    <= state_d;
      att_pull_o <= att_pull_d;
      dat_pull_o <= dat_pull_d;
      done_o     <= done_d;
      timeout_o  <= timeout_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/hs_link_tx_chk.sv
module hs_link_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic att_pull_o,
  input logic dat_pull_o,
  input logic busy_o,
  input logic done_o,
  input logic timeout_o
);

  // R4
  att_after_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(att_pull_o) |-> $stable(dat_pull_o));

  // R6
  data_moves_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(dat_pull_o) |-> (!$past(att_pull_o) || timeout_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !att_pull_o && !dat_pull_o));

  // R9
  timeout_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (!busy_o && !att_pull_o && !dat_pull_o && !done_o));

  // R9
  timeout_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  // R8
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || timeout_o));

endmodule

bind hs_link_tx hs_link_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .att_pull_o (att_pull_o),
  .dat_pull_o (dat_pull_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .timeout_o  (timeout_o)
);

// File: tb/hs_link_tx_bench.sv
`timescale 1ns/1ps
module hs_link_tx_bench;

  localparam int SETTLE = 4;
  localparam int HOLD   = 6;
  localparam int TMO    = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       start = 1'b0;
  logic       flag = 1'b0;
  logic [7:0] data = 8'h00;
  logic       att_pull, dat_pull, busy, done, tmo;

  // Bench controls
  logic rx_en = 1'b0;
  int   rx_delay = 0;
  logic rx_stuck = 1'b0;
  logic dat_hold = 1'b0;
  logic rx_clr = 1'b0;

  // Receiver / monitor state
  logic       rx_att;
  int         rx_phase, rx_cnt, rx_count;
  logic       rx_cap;
  logic [8:0] rx_word;
  int         done_cnt, to_cnt, att_rise, ack_cnt, r4_viol, stable;
  logic       dat_seen, prev_att, prev_dat;

  wire att_line = ~(att_pull | rx_att | rx_stuck);
  wire dat_line = ~(dat_pull | dat_hold);

  hs_link_tx #(
    .DATA_W      (8),
    .SETTLE_CYC  (SETTLE),
    .HOLD_CYC    (HOLD),
    .TIMEOUT_CYC (TMO)
  ) u_hs_link_tx (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .flag_i     (flag),
    .data_i     (data),
    .att_line_i (att_line),
    .dat_line_i (dat_line),
    .att_pull_o (att_pull),
    .dat_pull_o (dat_pull),
    .busy_o     (busy),
    .done_o     (done),
    .timeout_o  (tmo)
  );

  always @(negedge clk) begin
    if (rx_clr) begin
      rx_att <= 1'b0; rx_phase <= 0; rx_cnt <= 0; rx_count <= 0; rx_cap <= 1'b0;
      rx_word <= '0; done_cnt <= 0; to_cnt <= 0; att_rise <= 0; ack_cnt <= 0;
      r4_viol <= 0; stable <= 0; dat_seen <= 1'b0;
      prev_att <= att_pull; prev_dat <= dat_pull;
    end else begin
      // monitor
      if (done) done_cnt <= done_cnt + 1;
      if (tmo) to_cnt <= to_cnt + 1;
      if (dat_pull) dat_seen <= 1'b1;
      if (att_pull && !prev_att) begin
        att_rise <= att_rise + 1;
        if (stable < SETTLE - 1) r4_viol <= r4_viol + 1;
      end
      if (dat_pull != prev_dat) stable <= 0;
      else if (stable < 1000) stable <= stable + 1;
      if ((dat_pull != prev_dat) && rx_att) ack_cnt <= ack_cnt + 1;
      prev_att <= att_pull;
      prev_dat <= dat_pull;
      // receiver
      case (rx_phase)
        0: if (rx_en && !att_line) begin
             rx_cap <= dat_line; rx_cnt <= rx_delay; rx_phase <= 1;
           end
        1: if (rx_cnt == 0) begin rx_att <= 1'b1; rx_phase <= 2; end
           else rx_cnt <= rx_cnt - 1;
        default: if (dat_line != rx_cap) begin
             rx_att <= 1'b0; rx_phase <= 0;
             rx_word <= {rx_word[7:0], rx_cap}; rx_count <= rx_count + 1;
           end
      endcase
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_mon();
    tick(1); rx_clr = 1'b1;
    tick(1); rx_clr = 1'b0;
  endtask

  task automatic send(input logic f, input logic [7:0] d);
    tick(1);
    flag = f; data = d; start = 1'b1;
    tick(1);
    start = 1'b0;
  endtask

  task automatic wait_end(input int limit, output int cyc);
    int base;
    base = done_cnt + to_cnt;
    cyc = 0;
    while ((done_cnt + to_cnt) == base && cyc < limit) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    rx_clr = 1'b1;
    tick(3);
    @(negedge clk);
    check(att_pull == 1'b0, "R1 att_pull in reset", att_pull, 0);
    check(dat_pull == 1'b0, "R1 dat_pull in reset", dat_pull, 0);
    tick(1);
    rst_n = 1'b1;
    rx_clr = 1'b0;
    tick(5);
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(done == 1'b0 && tmo == 1'b0, "R1 done/timeout after reset", {done, tmo}, 0);
  endtask

  task automatic t_basic();
    int cyc;
    clear_mon();
    rx_en = 1'b1; rx_delay = 0;
    send(1'b1, 8'hA5);
    @(negedge clk);
    check(busy == 1'b1, "R8 busy during message", busy, 1);
    wait_end(3000, cyc);
    tick(1);
    @(negedge clk);
    check(rx_count == 9, "R2 bit count", rx_count, 9);
    check(rx_word == 9'h1A5, "R2 order flag then MSB first", rx_word, 9'h1A5);
    check(done_cnt == 1 && to_cnt == 0, "R8 single done, no timeout", done_cnt, 1);
    check(busy == 1'b0, "R8 busy low after done", busy, 0);
    check(!att_pull && !dat_pull, "R7 lines released after message", {att_pull, dat_pull}, 0);
    check(r4_viol == 0, "R4 data settled before attention", r4_viol, 0);
    check(ack_cnt == 9, "R6 data inverted while receiver holds attention", ack_cnt, 9);
    check(att_rise == 9, "R5 one pulse per bit with prompt receiver", att_rise, 9);
  endtask

  task automatic t_slow();
    int cyc;
    clear_mon();
    rx_en = 1'b1; rx_delay = 40;
    send(1'b0, 8'h3C);
    wait_end(5000, cyc);
    tick(1);
    @(negedge clk);
    check(rx_word == 9'h03C && rx_count == 9, "R2 slow receiver word", rx_word, 9'h03C);
    check(att_rise >= 18, "R5 attention re-pulsed while receiver slow", att_rise, 18);
    check(done_cnt == 1 && to_cnt == 0, "R5 slow receiver completes", done_cnt, 1);
    rx_delay = 0;
  endtask

  task automatic t_hold_data();
    int cyc;
    clear_mon();
    rx_en = 1'b1; dat_hold = 1'b1;
    send(1'b1, 8'h5A);
    tick(40);
    @(negedge clk);
    check(!dat_seen && att_rise == 0, "R3 no drive while Data held low", {dat_seen, att_rise[0]}, 0);
    check(busy == 1'b1, "R3 still waiting", busy, 1);
    tick(1);
    dat_hold = 1'b0;
    wait_end(3000, cyc);
    tick(1);
    check(rx_word == 9'h15A && done_cnt == 1, "R3 message after Data freed", rx_word, 9'h15A);
  endtask

  task automatic t_stuck();
    int cyc;
    clear_mon();
    rx_en = 1'b0; rx_stuck = 1'b1;
    send(1'b1, 8'hFF);
    wait_end(1000, cyc);
    @(negedge clk);
    check(cyc >= TMO - 5 && cyc <= TMO + 10, "R9 timeout window on stuck Attention", cyc, TMO);
    check(to_cnt == 1 && done_cnt == 0, "R9 timeout pulse without done", to_cnt, 1);
    check(!att_pull && !dat_pull && !busy, "R9 released and idle", {att_pull, dat_pull, busy}, 0);
    check(!dat_seen, "R3 Data untouched while Attention low", dat_seen, 0);
    tick(1);
    rx_stuck = 1'b0;
    tick(5);
  endtask

  task automatic t_silent();
    int cyc;
    clear_mon();
    rx_en = 1'b0;
    send(1'b0, 8'h00);
    wait_end(2000, cyc);
    @(negedge clk);
    check(to_cnt == 1 && done_cnt == 0, "R9 timeout on silent receiver", to_cnt, 1);
    check(att_rise > 1, "R5 polling before timeout", att_rise, 2);
    check(!att_pull && !dat_pull && !busy, "R9 lines freed after polling timeout", {att_pull, dat_pull, busy}, 0);
    tick(5);
  endtask

  task automatic t_busy_start();
    int cyc;
    clear_mon();
    rx_en = 1'b1; rx_delay = 0;
    send(1'b0, 8'h81);
    tick(30);
    send(1'b1, 8'h7E);
    wait_end(3000, cyc);
    tick(60);
    @(negedge clk);
    check(rx_word == 9'h081 && rx_count == 9, "R10 first message unchanged", rx_word, 9'h081);
    check(done_cnt == 1 && busy == 1'b0, "R10 no second message", done_cnt, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_basic();
        t_slow();
        t_hold_data();
        t_stuck();
        t_silent();
        t_busy_start();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule